// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a 32-lane execution unit and a memory bus. It accepts one memory request per warp, where every lane carries a 32-bit byte address for a 4-byte word and a flag saying whether the lane takes part. It works out which aligned memory segments the active lanes fall into. It then sends one bus transaction for each distinct segment, one per cycle, over a valid/ready handshake. Lanes that share a segment share one transaction, so a well-ordered warp costs a single bus beat, and a scattered warp costs as many beats as it touches segments.

A one-bit mode picks the segment granule. Mode 0 uses 128-byte lines and mode 1 uses 32-byte sectors. When the last transaction has been taken, the block raises a one-cycle completion flag. It then reports the number of transactions, the bytes actually needed (4 times the number of distinct active words) and the bytes moved across the bus (transactions times segment size). For every lane it also reports the index of the transaction that carries that lane's word, so that returned data can be steered back.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is captured on a cycle with `req_valid` and `req_ready` both high. While a request is in progress, `req_ready` stays low and `req_valid` has no effect on the transactions issued.
- R2: With `req_mode`=0 each transaction address is a multiple of 128. With `req_mode`=1 it is a multiple of 32. In both modes the address is the segment base containing the lanes it serves.
- R3: Exactly one transaction is issued for each distinct segment touched by an active lane. 32 lanes covering one aligned 128-byte block give one transaction in mode 0, whatever order the lanes use. A block that straddles a 128-byte boundary, starting 4 bytes past a 32-byte boundary, gives 2 transactions in mode 0 and 5 in mode 1.
- R4: Transactions of one request are issued in strictly ascending address order. `txn_id` counts them from 0.
- R5: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_addr` and `txn_id` hold their values. A transaction is accepted only on a cycle with both high.
- R6: Inactive lanes are ignored when segments are formed. A request with no active lanes issues no transaction and completes in the cycle after capture.
- R7: `done` is high for exactly one cycle: the cycle after the last transaction is accepted, or the cycle after capture for an empty request. In that cycle `txn_count` equals the number of accepted transactions.
- R8: From `done` until the next capture, `moved_bytes` equals `txn_count` times 128 in mode 0 or times 32 in mode 1. `useful_bytes` equals 4 times the number of distinct word addresses (address bits 31..2) among the active lanes.
- R9: From `done` until the next capture, the lane field `lane_txn_idx[5*i +: 5]` gives the `txn_id` of the transaction covering lane i. For an inactive lane it reads 0.
- R10: After reset the block is idle: `req_ready`=1, `txn_valid`=0, `done`=0, `txn_count`=0, `moved_bytes`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits 32*i +: 32 |
| req_active | input | 32 | Lane participation flags |
| req_mode | input | 1 | 0: 128-byte segments, 1: 32-byte segments |
| txn_valid | output | 1 | Bus transaction offered |
| txn_ready | input | 1 | Bus takes the transaction |
| txn_addr | output | 32 | Segment base address of the transaction |
| txn_id | output | 5 | Issue index of the transaction within the request |
| done | output | 1 | One-cycle completion flag |
| txn_count | output | 6 | Transactions issued for the last request |
| useful_bytes | output | 13 | Bytes the active lanes need |
| moved_bytes | output | 13 | Bytes moved over the bus |
| lane_txn_idx | output | 160 | Per-lane transaction index, lane i at bits 5*i +: 5 |

## Verification
On every cycle the assertions check the handshake rules and the bus-side properties. They cover the hold of a stalled transaction, the absence of `req_ready` while busy, segment alignment against the captured mode, and strictly rising addresses within a request. At completion they also check the single-cycle `done` pulse and the agreement of `txn_count` and `moved_bytes` with the accepted handshakes. The claims that depend on lane data can only be shown by the bench's scenarios against its reference model: that the number of segments is minimal, that every lane's segment appears, that the per-lane indices are right, and that the useful-byte count equals the distinct words. Those scenarios cover aligned, permuted, straddling, broadcast, scattered, partly active and empty warps under back-pressure.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int COAL_LANES   = 32;
    localparam int COAL_AW      = 32;
    localparam int WORD_SHIFT   = 2;
    localparam int LINE_SHIFT   = 7;
    localparam int SECTOR_SHIFT = 5;

    typedef enum logic {
        SEG_LINE   = 1'b0,
        SEG_SECTOR = 1'b1
    } seg_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } coal_state_e;

    // log2 of the segment size selected by the mode
    function automatic logic [2:0] seg_shift(input seg_mode_e m);
        return (m == SEG_SECTOR) ? 3'(SECTOR_SHIFT) : 3'(LINE_SHIFT);
    endfunction

endpackage

// File: rtl/coal_word_dedup.sv
module coal_word_dedup #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic [LANES*AW-1:0]       addr_flat,
    input  logic [LANES-1:0]          active,
    output logic [$clog2(LANES):0]    uniq_cnt
);
    import coal_pkg::*;

    localparam int CW = $clog2(LANES) + 1;

    logic [LANES-1:0] first_use;

    // a lane counts only if no lower active lane names the same word
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            first_use[i] = active[i];
            for (int j = 0; j < i; j++) begin
                if (active[j] &&
                    (((addr_flat[i*AW +: AW] ^ addr_flat[j*AW +: AW]) >> WORD_SHIFT) == '0))
                    first_use[i] = 1'b0;
            end
        end
    end

    always_comb begin
        uniq_cnt = '0;
        for (int i = 0; i < LANES; i++)
            uniq_cnt = uniq_cnt + CW'(first_use[i]);
    end

endmodule

// File: rtl/coal_min_finder.sv
module coal_min_finder #(
    parameter int N  = 32,
    parameter int KW = 32
) (
    input  logic [N-1:0]    cand_valid,
    input  logic [N*KW-1:0] cand_key,
    output logic            any_valid,
    output logic [KW-1:0]   min_key
);
    localparam int NODES = 2 * N - 1;

    logic          nv [NODES];
    logic [KW-1:0] nk [NODES];

    // heap-ordered comparison tree: leaves at N-1 .. 2N-2
    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign nv[N-1+i] = cand_valid[i];
        assign nk[N-1+i] = cand_key[i*KW +: KW];
    end

    for (genvar n = 0; n < N - 1; n++) begin : g_node
        logic take_left;
        assign take_left = nv[2*n+1] && (!nv[2*n+2] || (nk[2*n+1] <= nk[2*n+2]));
        assign nv[n]     = nv[2*n+1] | nv[2*n+2];
        assign nk[n]     = take_left ? nk[2*n+1] : nk[2*n+2];
    end

    assign any_valid = nv[0];
    assign min_key   = nk[0];

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES = coal_pkg::COAL_LANES,
    parameter int AW    = coal_pkg::COAL_AW
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic [LANES*AW-1:0]                req_addr,
    input  logic [LANES-1:0]                   req_active,
    input  logic                               req_mode,
    output logic                               txn_valid,
    input  logic                               txn_ready,
    output logic [AW-1:0]                      txn_addr,
    output logic [$clog2(LANES)-1:0]           txn_id,
    output logic                               done,
    output logic [$clog2(LANES):0]             txn_count,
    output logic [$clog2(LANES*128):0]         useful_bytes,
    output logic [$clog2(LANES*128):0]         moved_bytes,
    output logic [LANES*$clog2(LANES)-1:0]     lane_txn_idx
);
    import coal_pkg::*;

    localparam int TIDX_W = $clog2(LANES);
    localparam int CNT_W  = TIDX_W + 1;
    localparam int BW     = $clog2(LANES * 128) + 1;

    coal_state_e         state_q;
    seg_mode_e           mode_q;
    logic [AW-1:0]       addr_q [LANES];
    logic [LANES-1:0]    pend_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    uniq_q;
    logic [TIDX_W-1:0]   lidx_q [LANES];

    logic [CNT_W-1:0]    uniq_in;
    logic [LANES*AW-1:0] seg_flat;
    logic [LANES-1:0]    seg_hit;
    logic                any_pend;
    logic [AW-1:0]       min_seg;
    logic [2:0]          sh;
    logic                accept;
    logic                handshake;

    assign sh = seg_shift(mode_q);

    // segment base of each captured lane address
    for (genvar i = 0; i < LANES; i++) begin : g_seg
        assign seg_flat[i*AW +: AW] = (addr_q[i] >> sh) << sh;
        assign seg_hit[i]           = pend_q[i] && (seg_flat[i*AW +: AW] == min_seg);
    end

    coal_min_finder #(.N(LANES), .KW(AW)) u_min (
        .cand_valid (pend_q),
        .cand_key   (seg_flat),
        .any_valid  (any_pend),
        .min_key    (min_seg)
    );

    coal_word_dedup #(.LANES(LANES), .AW(AW)) u_dedup (
        .addr_flat (req_addr),
        .active    (req_active),
        .uniq_cnt  (uniq_in)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign txn_valid = (state_q == ST_ISSUE) && any_pend;
    assign done      = (state_q == ST_ISSUE) && !any_pend;
    assign handshake = txn_valid && txn_ready;

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < LANES; i++)
                addr_q[i] <= req_addr[i*AW +: AW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= SEG_LINE;
            pend_q  <= '0;
            cnt_q   <= '0;
            uniq_q  <= '0;
            for (int i = 0; i < LANES; i++)
                lidx_q[i] <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_ISSUE;
                        mode_q  <= seg_mode_e'(req_mode);
                        pend_q  <= req_active;
                        cnt_q   <= '0;
                        uniq_q  <= uniq_in;
                        for (int i = 0; i < LANES; i++)
                            lidx_q[i] <= '0;
                    end
                end
                default: begin
                    if (!any_pend) begin
                        state_q <= ST_IDLE;
                    end else if (txn_ready) begin
                        pend_q <= pend_q & ~seg_hit;
                        cnt_q  <= cnt_q + 1'b1;
                        for (int i = 0; i < LANES; i++)
                            if (seg_hit[i])
                                lidx_q[i] <= cnt_q[TIDX_W-1:0];
                    end
                end
            endcase
        end
    end

    assign txn_addr     = min_seg;
    assign txn_id       = cnt_q[TIDX_W-1:0];
    assign txn_count    = cnt_q;
    assign useful_bytes = BW'(uniq_q) << WORD_SHIFT;
    assign moved_bytes  = BW'(cnt_q) << sh;

    for (genvar i = 0; i < LANES; i++) begin : g_lidx
        assign lane_txn_idx[i*TIDX_W +: TIDX_W] = lidx_q[i];
    end

endmodule

// File: rtl/warp_coalescer_checker.sv
module warp_coalescer_checker #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic                        req_mode,
    input logic                        txn_valid,
    input logic                        txn_ready,
    input logic [AW-1:0]               txn_addr,
    input logic [$clog2(LANES)-1:0]    txn_id,
    input logic                        done,
    input logic [$clog2(LANES):0]      txn_count,
    input logic [$clog2(LANES*128):0]  useful_bytes,
    input logic [$clog2(LANES*128):0]  moved_bytes
);
    localparam int CNT_W = $clog2(LANES) + 1;
    localparam int BW    = $clog2(LANES * 128) + 1;

    logic             mode_c;
    logic             have_last;
    logic [AW-1:0]    last_addr;
    logic [CNT_W-1:0] hs_cnt;
    logic [AW-1:0]    align_mask;
    logic [BW-1:0]    seg_bytes;

    assign align_mask = mode_c ? AW'(31) : AW'(127);
    assign seg_bytes  = mode_c ? BW'(32) : BW'(128);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_c    <= 1'b0;
            have_last <= 1'b0;
            last_addr <= '0;
            hs_cnt    <= '0;
        end else if (req_valid && req_ready) begin
            mode_c    <= req_mode;
            have_last <= 1'b0;
            hs_cnt    <= '0;
        end else if (txn_valid && txn_ready) begin
            have_last <= 1'b1;
            last_addr <= txn_addr;
            hs_cnt    <= hs_cnt + 1'b1;
        end
    end

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> !req_ready);

    a_r1_accept_goes_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_segment_aligned: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> ((txn_addr & align_mask) == '0));

    a_r4_ascending: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && have_last) |-> (txn_addr > last_addr));

    a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_id)));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_count_matches: assert property (@(posedge clk) disable iff (rst)
        done |-> (txn_count == hs_cnt));

    a_r8_moved_bytes: assert property (@(posedge clk) disable iff (rst)
        done |-> (moved_bytes == BW'(hs_cnt) * seg_bytes));

    a_r8_useful_bounded: assert property (@(posedge clk) disable iff (rst)
        done |-> (useful_bytes <= moved_bytes));

endmodule

bind warp_coalescer warp_coalescer_checker #(.LANES(LANES), .AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_mode     (req_mode),
    .txn_valid    (txn_valid),
    .txn_ready    (txn_ready),
    .txn_addr     (txn_addr),
    .txn_id       (txn_id),
    .done         (done),
    .txn_count    (txn_count),
    .useful_bytes (useful_bytes),
    .moved_bytes  (moved_bytes)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
    localparam int NL = 32;
    localparam int TW = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [NL*32-1:0] req_addr = '0;
    logic [NL-1:0]   req_active = '0;
    logic            req_mode = 1'b0;
    logic            txn_valid;
    logic            txn_ready = 1'b0;
    logic [31:0]     txn_addr;
    logic [TW-1:0]   txn_id;
    logic            done;
    logic [5:0]      txn_count;
    logic [12:0]     useful_bytes;
    logic [12:0]     moved_bytes;
    logic [NL*TW-1:0] lane_txn_idx;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    warp_coalescer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_active(req_active), .req_mode(req_mode),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_id(txn_id), .done(done), .txn_count(txn_count),
        .useful_bytes(useful_bytes), .moved_bytes(moved_bytes),
        .lane_txn_idx(lane_txn_idx)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference model plus driver for one warp request
    task automatic run_req(input logic [31:0] a [NL], input logic [NL-1:0] act,
                           input logic md, input int rdy_pct, input bit poke);
        logic [31:0] segs[$];
        logic [31:0] words[$];
        int exp_idx[NL];
        int sh, k, nseg;
        bit seen;
        logic [31:0] b;
        sh = md ? 5 : 7;
        for (int i = 0; i < NL; i++) begin
            if (act[i]) begin
                b = (a[i] >> sh) << sh;
                seen = 0;
                foreach (segs[s]) if (segs[s] == b) seen = 1;
                if (!seen) segs.push_back(b);
                b = a[i] >> 2;
                seen = 0;
                foreach (words[s]) if (words[s] == b) seen = 1;
                if (!seen) words.push_back(b);
            end
        end
        segs.sort();
        nseg = segs.size();
        for (int i = 0; i < NL; i++) begin
            exp_idx[i] = 0;
            if (act[i]) foreach (segs[s]) if (segs[s] == ((a[i] >> sh) << sh)) exp_idx[i] = s;
        end

        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
        for (int i = 0; i < NL; i++) req_addr[i*32 +: 32] = a[i];
        req_active = act;
        req_mode   = md;
        req_valid  = 1'b1;
        @(negedge clk);
        k = 0;
        forever begin
            req_valid = poke && (k < nseg);
            if (poke) begin
                req_addr   = {NL{32'hDEAD_0000}};
                req_active = '1;
                req_mode   = ~md;
            end
            txn_ready = ($urandom % 100) < rdy_pct;
            #1;
            if (k < nseg) begin
                check(txn_valid == 1'b1, "R3 txn offered", txn_valid, 1);
                check(txn_addr == segs[k], "R2/R4 segment address", txn_addr, segs[k]);
                check(txn_id == TW'(k), "R4 txn index", txn_id, k);
                check(done == 1'b0, "R7 no early done", done, 0);
                check(req_ready == 1'b0, "R1 busy", req_ready, 0);
                if (txn_ready) k++;
            end else begin
                check(done == 1'b1, "R7 done pulse", done, 1);
                check(txn_valid == 1'b0, "R3/R6 no extra txn", txn_valid, 0);
                check(txn_count == 6'(nseg), "R7 txn count", txn_count, nseg);
                check(moved_bytes == 13'(nseg << sh), "R8 moved bytes", moved_bytes, nseg << sh);
                check(useful_bytes == 13'(words.size() * 4), "R8 useful bytes",
                      useful_bytes, words.size() * 4);
                for (int i = 0; i < NL; i++)
                    check(lane_txn_idx[i*TW +: TW] == TW'(exp_idx[i]), "R9 lane index",
                          lane_txn_idx[i*TW +: TW], exp_idx[i]);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        txn_ready = 1'b0;
        #1;
        check(done == 1'b0, "R7 done one cycle", done, 0);
        check(req_ready == 1'b1, "R1 idle after done", req_ready, 1);
        check(moved_bytes == 13'(nseg << sh), "R8 stats held", moved_bytes, nseg << sh);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a [NL];
        logic [NL-1:0] act;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
        check(txn_valid == 1'b0, "R10 reset txn_valid", txn_valid, 0);
        check(done == 1'b0, "R10 reset done", done, 0);
        check(txn_count == 0, "R10 reset count", txn_count, 0);
        check(moved_bytes == 0, "R10 reset moved", moved_bytes, 0);

        // R3: aligned consecutive words, both modes
        for (int i = 0; i < NL; i++) a[i] = 32'h1000 + 4 * i;
        run_req(a, '1, 1'b0, 100, 0);
        run_req(a, '1, 1'b1, 100, 0);
        // R3: permuted lanes inside one line
        for (int i = 0; i < NL; i++) a[i] = 32'h2000 + 4 * ((i * 7) % NL);
        run_req(a, '1, 1'b0, 100, 0);
        // R3: straddling pattern, 2 lines / 5 sectors
        for (int i = 0; i < NL; i++) a[i] = 32'h3044 + 4 * i;
        run_req(a, '1, 1'b0, 100, 0);
        run_req(a, '1, 1'b1, 100, 0);
        // R8: broadcast of a single word
        for (int i = 0; i < NL; i++) a[i] = 32'h5010;
        run_req(a, '1, 1'b0, 100, 0);
        run_req(a, '1, 1'b1, 100, 0);
        // R4: scattered segments, unordered in lane order
        for (int i = 0; i < NL; i++) a[i] = 32'h10000 + ((i * 37) % 8) * 32'h400 + 4 * (i % 3);
        run_req(a, '1, 1'b0, 100, 0);
        run_req(a, '1, 1'b1, 60, 0);
        // R6: inactive lanes carry far-away addresses
        for (int i = 0; i < NL; i++) a[i] = (i % 2) ? 32'hF000_0000 + 256 * i : 32'h4000 + 4 * i;
        act = 32'h5555_5555;
        run_req(a, act, 1'b0, 100, 0);
        // R6: empty request
        run_req(a, '0, 1'b1, 100, 0);
        // R5/R1: back-pressure with a competing request held high
        for (int i = 0; i < NL; i++) a[i] = 32'h8000 + 32'h90 * i;
        run_req(a, '1, 1'b1, 30, 1);
        // random mixes
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < NL; i++) a[i] = 32'h20000 + (($urandom % 64) << 2) * (1 + t % 5);
            act = $urandom;
            run_req(a, act, 1'($urandom % 2), 50, t % 3 == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule